// File: doc/BRIEF.md
# PHY control register bank with half-word write masking

This block is a small set of 32-bit control registers for a PHY, reached over a plain bus made of an address, a write data word, a write strobe and a combinational read data word. Each writable register stores only 16 bits. The upper half of every write word acts as a per-bit enable for the lower half. Software can therefore set or clear one field in a single write, with no read-modify-write.

Three registers are mapped. The configuration register drives the PHY's serial configuration port: a write pulse, a 6-bit address and a 4-bit data nibble. The lane register holds one idle-off control for each of four lanes. The status register is read-only and shows two PLL flags, which it samples from input pins on every clock.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On a write to a writable register, stored bit x (x in 0..15) takes write data bit x only when write data bit x+16 is 1 in the same word.
- R2: A stored bit whose enable bit is 0 keeps its value. A register that is not addressed keeps all of its bits. Cycles with no write strobe change nothing.
- R3: The register is selected by the full 16-bit address: configuration at 0xe220, lane control at 0xe214, status at 0xe2a4.
- R4: The configuration outputs follow the stored configuration bits: the write pulse is bit 0, the port address is bits 6:1 and the port data is bits 10:7. Bits 15:11 are stored and read back.
- R5: The lane idle-off output n (n = 0..3, lanes A..D) equals lane register bit 3+n. A 1 puts the lane in idle-off and a 0 releases it. The other bits of the lane register are stored and read back.
- R6: A status read returns the PLL-locked input in bit 9 and the PLL-output-pending input in bit 10, and zero in every other bit. The inputs are sampled at each clock edge, so a change becomes readable after the next edge and not before it.
- R7: Every read returns zero in bits 31:16. The enable half of a write is never stored.
- R8: A write to the status address changes no stored bit in any register.
- R9: A read of any unmapped address returns zero. A write to an unmapped address changes no register.
- R10: Reset, asynchronous and active low, clears every stored bit. After reset, all outputs are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write word: enables in 31:16, values in 15:0 |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for bus_addr |
| pll_locked_i | input | 1 | PLL lock flag from the PHY |
| pll_out_pending_i | input | 1 | PLL output-enable still pending, from the PHY |
| cfg_wr_o | output | 1 | Configuration port write pulse |
| cfg_addr_o | output | 6 | Configuration port address |
| cfg_data_o | output | 4 | Configuration port data |
| lane_idle_off_o | output | 4 | Idle-off control per lane, A in bit 0 |

## Verification
The bench builds the block with its default parameters: 16 stored bits per register, four lanes starting at bit 3, and the three default offsets. This register width is small enough that every single-bit enable, in both polarities, can be walked through both writable registers, followed by a few dozen pseudo-random mask and data words checked against an arithmetic model. The bench also sweeps a 256-byte address window around the map, which covers every unmapped read in that window and the misaligned neighbours of each mapped offset. All four combinations of the PLL inputs are applied, and the one-cycle sampling delay is checked.

// File: rtl/phy_ctl_regbank_pkg.sv
package phy_ctl_regbank_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_LANE = 2'd2,
    SEL_STS  = 2'd3
  } reg_sel_e;

  // Resulting stored word after a half-word masked write.
  function automatic logic [15:0] masked_merge(input logic [15:0] old_val,
                                               input logic [15:0] new_val,
                                               input logic [15:0] en);
    masked_merge = (old_val & ~en) | (new_val & en);
  endfunction

endpackage

// File: rtl/phy_ctl_addr_decode.sv
module phy_ctl_addr_decode
  import phy_ctl_regbank_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] CFG_OFS  = 16'he220,
  parameter logic [15:0] LANE_OFS = 16'he214,
  parameter logic [15:0] STS_OFS  = 16'he2a4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output logic              cfg_wr_sel,
  output logic              lane_wr_sel
);

  localparam logic [ADDR_W-1:0] CfgA  = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] LaneA = ADDR_W'(LANE_OFS);
  localparam logic [ADDR_W-1:0] StsA  = ADDR_W'(STS_OFS);

  always_comb begin
    sel = SEL_NONE;
    if (addr == CfgA)       sel = SEL_CFG;
    else if (addr == LaneA) sel = SEL_LANE;
    else if (addr == StsA)  sel = SEL_STS;
  end

  // The status select never produces a write select.
  assign cfg_wr_sel  = we && (sel == SEL_CFG);
  assign lane_wr_sel = we && (sel == SEL_LANE);

endmodule

// File: rtl/phy_ctl_masked_reg.sv
module phy_ctl_masked_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_sel,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] d;
  logic [W-1:0] en_bits;
  logic         clk_en;

  // Next state, one bit at a time.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign en_bits[i] = wr_sel & wdata[W+i];
    assign d[i]       = en_bits[i] ? wdata[i] : q[i];
  end

  assign clk_en = |en_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clk_en) q <= d;
  end

endmodule

// File: rtl/phy_ctl_status_sampler.sv
module phy_ctl_status_sampler #(
  parameter int W        = 16,
  parameter int LOCK_BIT = 9,
  parameter int PEND_BIT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pll_locked_i,
  input  logic         pll_out_pending_i,
  output logic [W-1:0] q
);

  logic [W-1:0] d;
  logic         clk_en;

  always_comb begin
    d           = '0;
    d[LOCK_BIT] = pll_locked_i;
    d[PEND_BIT] = pll_out_pending_i;
  end

  assign clk_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clk_en) q <= d;
  end

endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_ctl_regbank_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          REG_W    = 16,
  parameter int          LANES    = 4,
  parameter int          LANE_LSB = 3,
  parameter logic [15:0] CFG_OFS  = 16'he220,
  parameter logic [15:0] LANE_OFS = 16'he214,
  parameter logic [15:0] STS_OFS  = 16'he2a4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [2*REG_W-1:0]  bus_wdata,
  input  logic                bus_we,
  output logic [2*REG_W-1:0]  bus_rdata,
  input  logic                pll_locked_i,
  input  logic                pll_out_pending_i,
  output logic                cfg_wr_o,
  output logic [5:0]          cfg_addr_o,
  output logic [3:0]          cfg_data_o,
  output logic [LANES-1:0]    lane_idle_off_o
);

  localparam int CfgAddrLsb = 1;
  localparam int CfgDataLsb = 7;

  reg_sel_e        sel;
  logic            cfg_wr_sel;
  logic            lane_wr_sel;
  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] lane_q;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] rd_low;

  phy_ctl_addr_decode #(
    .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .LANE_OFS(LANE_OFS), .STS_OFS(STS_OFS)
  ) i_dec (
    .addr(bus_addr), .we(bus_we), .sel(sel),
    .cfg_wr_sel(cfg_wr_sel), .lane_wr_sel(lane_wr_sel)
  );

  phy_ctl_masked_reg #(.W(REG_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_sel(cfg_wr_sel), .wdata(bus_wdata), .q(cfg_q)
  );

  phy_ctl_masked_reg #(.W(REG_W)) i_lane (
    .clk(clk), .rst_n(rst_n), .wr_sel(lane_wr_sel), .wdata(bus_wdata), .q(lane_q)
  );

  phy_ctl_status_sampler #(.W(REG_W)) i_sts (
    .clk(clk), .rst_n(rst_n), .pll_locked_i(pll_locked_i),
    .pll_out_pending_i(pll_out_pending_i), .q(sts_q)
  );

  always_comb begin
    case (sel)
      SEL_CFG:  rd_low = cfg_q;
      SEL_LANE: rd_low = lane_q;
      SEL_STS:  rd_low = sts_q;
      default:  rd_low = '0;
    endcase
  end

  assign bus_rdata = {{REG_W{1'b0}}, rd_low};

  assign cfg_wr_o   = cfg_q[0];
  assign cfg_addr_o = cfg_q[CfgAddrLsb +: 6];
  assign cfg_data_o = cfg_q[CfgDataLsb +: 4];

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign lane_idle_off_o[n] = lane_q[LANE_LSB+n];
  end

endmodule

// File: rtl/phy_ctl_regbank_chk.sv
module phy_ctl_regbank_chk #(
  parameter int REG_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        bus_addr,
  input logic [2*REG_W-1:0] bus_wdata,
  input logic               bus_we,
  input logic [2*REG_W-1:0] bus_rdata,
  input logic               pll_locked_i,
  input logic               pll_out_pending_i,
  input logic [REG_W-1:0]   cfg_q,
  input logic [REG_W-1:0]   lane_q
);

  logic cfg_hit, lane_hit, mapped;
  assign cfg_hit  = bus_addr == 16'he220;
  assign lane_hit = bus_addr == 16'he214;
  assign mapped   = cfg_hit || lane_hit || bus_addr == 16'he2a4;

  a_r1_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && cfg_hit |=>
      (cfg_q & $past(bus_wdata[31:16])) == ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16])));

  a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && lane_hit |=>
      (lane_q & ~$past(bus_wdata[31:16])) == ($past(lane_q) & ~$past(bus_wdata[31:16])));

  a_r8_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (cfg_hit || lane_hit)) |=> $stable(cfg_q) && $stable(lane_q));

  a_r6_lock_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 16'he2a4 && $stable(bus_addr) |->
      bus_rdata[9] == $past(pll_locked_i) && bus_rdata[10] == $past(pll_out_pending_i));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == 32'h0);

endmodule

bind phy_ctl_regbank phy_ctl_regbank_chk #(.REG_W(REG_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .pll_locked_i(pll_locked_i),
  .pll_out_pending_i(pll_out_pending_i), .cfg_q(cfg_q), .lane_q(lane_q)
);

// File: tb/test_phy_ctl_regbank.sv
module test_phy_ctl_regbank;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_CFG  = 16'he220;
  localparam logic [15:0] A_LANE = 16'he214;
  localparam logic [15:0] A_STS  = 16'he2a4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic        pll_locked_i, pll_out_pending_i;
  logic        cfg_wr_o;
  logic [5:0]  cfg_addr_o;
  logic [3:0]  cfg_data_o;
  logic [3:0]  lane_idle_off_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] m_cfg, m_lane;
  logic [31:0] seed;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_ctl_regbank i_phy_ctl_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pll_locked_i(pll_locked_i),
    .pll_out_pending_i(pll_out_pending_i), .cfg_wr_o(cfg_wr_o),
    .cfg_addr_o(cfg_addr_o), .cfg_data_o(cfg_data_o),
    .lane_idle_off_o(lane_idle_off_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Drive a write for one cycle; returns at the next falling edge.
  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = 32'h0;
    if (a == A_CFG)  m_cfg  = (m_cfg  & ~d[31:16]) | (d[15:0] & d[31:16]);
    if (a == A_LANE) m_lane = (m_lane & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] r;
    bus_read(A_CFG, r);
    check({req, " cfg"}, r, {16'h0, m_cfg});
    bus_read(A_LANE, r);
    check({req, " lane"}, r, {16'h0, m_lane});
    check("R4 cfg outputs", {21'h0, cfg_data_o, cfg_addr_o, cfg_wr_o}, {21'h0, m_cfg[10:0]});
    check("R5 lane outputs", {28'h0, lane_idle_off_o}, {28'h0, m_lane[6:3]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    bus_addr = 16'h0; bus_wdata = 32'h0; bus_we = 1'b0;
    pll_locked_i = 1'b0; pll_out_pending_i = 1'b0;
    m_cfg = 16'h0; m_lane = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check_all("R10 reset");
    bus_read(A_STS, r);
    check("R10 status reset", r, 32'h0);

    // R1/R2: walk every single enable bit, set then clear, in both registers
    for (int i = 0; i < 16; i++) begin
      bus_write(A_CFG, (32'h1 << (i + 16)) | 32'h0000_ffff);
      check_all("R1 cfg walk set");
      bus_write(A_LANE, (32'h1 << (i + 16)) | 32'h0000_ffff);
      check_all("R1 lane walk set");
    end
    for (int i = 0; i < 16; i++) begin
      bus_write(A_CFG, 32'h1 << (i + 16));
      check_all("R2 cfg walk clear");
      bus_write(A_LANE, (32'h1 << (i + 16)) | 32'h0000_ffff & ~(32'h1 << i));
      check_all("R2 lane walk clear");
    end

    // R2: data without enables changes nothing
    bus_write(A_CFG, 32'h0000_ffff);
    check_all("R2 zero enables");

    // R5: each lane individually idled then released
    bus_write(A_LANE, 32'hffff_0000);
    for (int n = 0; n < 4; n++) begin
      bus_write(A_LANE, (32'h1 << (n + 3 + 16)) | (32'h1 << (n + 3)));
      check("R5 lane idle-off", {28'h0, lane_idle_off_o}, 32'h1 << n);
      bus_write(A_LANE, 32'h1 << (n + 3 + 16));
      check("R5 lane release", {28'h0, lane_idle_off_o}, 32'h0);
    end

    // R1/R2/R4: pseudo-random masked writes
    seed = 32'h1234_5678;
    for (int k = 0; k < 40; k++) begin
      seed = next_rand(seed);
      bus_write((k % 2) ? A_LANE : A_CFG, seed);
      check_all("R1 random");
    end

    // R8: status write ignored
    bus_write(A_STS, 32'hffff_ffff);
    check_all("R8 status write");
    bus_read(A_STS, r);
    check("R8 status unchanged", r, 32'h0);

    // R3/R9: address sweep, unmapped reads zero, unmapped writes inert
    for (int a = 16'he200; a < 16'he300; a++) begin
      if (a[15:0] != A_CFG && a[15:0] != A_LANE && a[15:0] != A_STS) begin
        bus_read(a[15:0], r);
        check("R9 unmapped read", r, 32'h0);
      end
    end
    bus_write(16'he221, 32'hffff_ffff);
    bus_write(16'he215, 32'hffff_ffff);
    bus_write(16'h0220, 32'hffff_0000);
    check_all("R3 R9 unmapped write");

    // R6/R7: status sampling, every input combination
    for (int c = 0; c < 4; c++) begin
      bus_read(A_STS, r);
      @(negedge clk);
      pll_locked_i = c[0];
      pll_out_pending_i = c[1];
      bus_read(A_STS, r);
      // not yet sampled: previous combination still visible
      check("R6 before edge", r, (c == 0) ? 32'h0 : {21'h0, 1'(c - 1 >> 1), 1'((c - 1) & 1), 9'h0});
      @(negedge clk);
      bus_read(A_STS, r);
      check("R6 after edge", r, {21'h0, c[1], c[0], 9'h0});
      check("R7 upper zero", {16'h0, r[31:16]}, 32'h0);
    end

    // R10: reset mid-run clears all
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_cfg = 16'h0; m_lane = 16'h0;
    check_all("R10 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(A_STS, r);
    check("R10 status after reset", r, {21'h0, 1'b1, 1'b1, 9'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule